// File: doc/BRIEF.md
# Shadow Register Update Controller

This block holds the timing and configuration values for a two-output PWM generator in two layers. Software writes a staging layer at any time. The waveform logic reads only an active layer. The controller moves the whole staged set into the active layer in one step, so the generator never runs a cycle with a mix of old and new values.

The transfer follows the generator's state. When the generator is stopped, a write reaches the active layer at once. When it is running, a transfer happens only on the end-of-cycle strobe, and two control bits can hold it back:

- A hold bit blocks transfers while it is set.
- A trigger-on-write mode makes the transfer wait for a write to output B's reset compare value.

A third control bit makes output A mirror output B's compare values. Each active load raises a one-cycle done pulse.

Top module: `shadow_update_ctrl`

## Requirements
- R1: Synchronous active-high reset clears every staged value, every active value, the holding byte, all control bits, the pending flag and `upd_done`.
- R2: While `run` is low, a write to a staged register shows on the active outputs one clock after the write. `upd_done` pulses in that same cycle.
- R3: While `run` is high and neither control bit is in force, pending values stay out of the active outputs until a cycle with `eoc` high. They are loaded on that clock edge.
- R4: In trigger-on-write mode (control bit 1) while running, a transfer at `eoc` needs a low-byte write to output B's reset compare (address 11) since the last transfer. Writes to other registers alone never move data.
- R5: Setting or clearing control bit 1 takes effect only after the next `eoc`. The `eoc` that follows the write still follows the previous rule.
- R6: While the hold bit (control bit 0) is set and trigger-on-write is not in force, nothing transfers while running. Clearing the hold bit does not transfer by itself. The pending set moves at the next `eoc`.
- R7: With both control bits in force, trigger-on-write decides and the hold bit is ignored.
- R8: When control bit 2 is set, `act_a_set` and `act_a_rst` show the active output-B set and reset values. When it is clear, they show output A's own values. The bit acts one clock after its write.
- R9: The address map is:
  - Address 0 is control.
  - Address 1 is the 8-bit output configuration.
  - Address 2 is the mode bit, taken from data bit 0.
  - Addresses 4 to 11 are compare bytes in the order A-set, A-reset, B-set, B-reset. For each, the even address is the high byte and the odd address is the low byte.
  
  A high-byte write only fills a 4-bit holding register and changes nothing else. The low-byte write commits the 12-bit value {holding[3:0], data}.
- R10: An `eoc` with nothing pending produces no transfer and no `upd_done`.
- R11: A staged write in the same cycle as a transferring `eoc` is not part of that transfer. It stays pending for the next one.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 4 | Register address |
| wr_data | input | 8 | Write data byte |
| run | input | 1 | Generator running |
| eoc | input | 1 | End-of-cycle strobe from the PWM counter |
| act_cfg | output | 8 | Active output configuration |
| act_mode | output | 1 | Active mode bit |
| act_a_set | output | 12 | Active output-A set compare (mirrored in fifty-percent mode) |
| act_a_rst | output | 12 | Active output-A reset compare (mirrored in fifty-percent mode) |
| act_b_set | output | 12 | Active output-B set compare |
| act_b_rst | output | 12 | Active output-B reset compare |
| upd_done | output | 1 | One-cycle pulse when the active set is loaded |

## Verification
A stale pending flag shows as a done pulse on an `eoc` with no new writes. A lost pending flag shows as a running write that never reaches the outputs. In both cases the error appears one clock after the first `eoc` that follows.

A delayed trigger-on-write flag that is wrong moves or holds back the whole set at the first `eoc` after the control write. A wrong holding byte corrupts the upper nibble of the very next committed compare value.

The reference model predicts every output in every cycle, so each of these errors appears within one clock of the edge where it occurs.

// File: rtl/shadow_pkg.sv
package shadow_pkg;
    parameter int DATA_W = 8;
    parameter int CMP_W  = 12;
    parameter int CFG_W  = 8;
    parameter int ADDR_W = 4;
    parameter int N_CMP  = 4;
    localparam int HI_W  = CMP_W - DATA_W;
    localparam int SEL_W = $clog2(N_CMP);

    typedef logic [CMP_W-1:0] cmp_t;

    typedef enum logic [SEL_W-1:0] {
        CMP_A_SET = 2'd0,
        CMP_A_RST = 2'd1,
        CMP_B_SET = 2'd2,
        CMP_B_RST = 2'd3
    } cmp_sel_e;

    typedef struct packed {
        logic [CFG_W-1:0]     cfg;
        logic                 mode;
        cmp_t [N_CMP-1:0]     cmp;
    } regset_t;

    // bit 0 hold, bit 1 trigger-on-write, bit 2 mirror
    typedef struct packed {
        logic fifty;
        logic autolock;
        logic lock;
    } ctrl_t;
    localparam int CTRL_W = $bits(ctrl_t);

    localparam logic [ADDR_W-1:0] ADDR_CTRL     = 4'd0;
    localparam logic [ADDR_W-1:0] ADDR_CFG      = 4'd1;
    localparam logic [ADDR_W-1:0] ADDR_MODE     = 4'd2;
    localparam logic [ADDR_W-1:0] ADDR_CMP_BASE = 4'd4;

    typedef enum logic [2:0] {
        WK_NONE, WK_CTRL, WK_CFG, WK_MODE, WK_CMP_HI, WK_CMP_LO
    } wkind_e;

    typedef struct packed {
        wkind_e            kind;
        cmp_sel_e          sel;
        logic [DATA_W-1:0] data;
    } wdec_t;

    typedef enum logic [1:0] {
        POL_FREE, POL_HOLD, POL_TRIGGER
    } policy_e;

    function automatic wdec_t decode_write(input logic en,
                                           input logic [ADDR_W-1:0] a,
                                           input logic [DATA_W-1:0] d);
        wdec_t r;
        logic [ADDR_W-1:0] off;
        r.kind = WK_NONE;
        r.sel  = CMP_A_SET;
        r.data = d;
        off    = a - ADDR_CMP_BASE;
        if (en) begin
            if (a == ADDR_CTRL)      r.kind = WK_CTRL;
            else if (a == ADDR_CFG)  r.kind = WK_CFG;
            else if (a == ADDR_MODE) r.kind = WK_MODE;
            else if (a >= ADDR_CMP_BASE && int'(off) < 2 * N_CMP) begin
                r.sel  = cmp_sel_e'(off[SEL_W:1]);
                r.kind = off[0] ? WK_CMP_LO : WK_CMP_HI;
            end
        end
        return r;
    endfunction

    // trigger-on-write outranks the hold bit
    function automatic policy_e pick_policy(input logic trig_eff, input logic hold);
        if (trig_eff)  return POL_TRIGGER;
        else if (hold) return POL_HOLD;
        else           return POL_FREE;
    endfunction
endpackage

// File: rtl/shadow_stage.sv
module shadow_stage
    import shadow_pkg::*;
(
    input  logic    clk,
    input  logic    rst,
    input  wdec_t   wd_i,
    input  logic    xfer_i,
    output regset_t staged_o,
    output ctrl_t   ctrl_o,
    output logic    pending_o,
    output logic    rb_seen_o
);
    regset_t         staged_q;
    ctrl_t           ctrl_q;
    logic [HI_W-1:0] hold_q;
    logic            pending_q;
    logic            rb_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            staged_q  <= '0;
            ctrl_q    <= '0;
            hold_q    <= '0;
            pending_q <= 1'b0;
            rb_q      <= 1'b0;
        end else begin
            // Clear on transfer first; a write in the same cycle sets the flags again.
            if (xfer_i) begin
                pending_q <= 1'b0;
                rb_q      <= 1'b0;
            end
            case (wd_i.kind)
                WK_CTRL: ctrl_q <= ctrl_t'(wd_i.data[CTRL_W-1:0]);
                WK_CFG: begin
                    staged_q.cfg <= wd_i.data[CFG_W-1:0];
                    pending_q    <= 1'b1;
                end
                WK_MODE: begin
                    staged_q.mode <= wd_i.data[0];
                    pending_q     <= 1'b1;
                end
                WK_CMP_HI: hold_q <= wd_i.data[HI_W-1:0];
                WK_CMP_LO: begin
                    staged_q.cmp[wd_i.sel] <= {hold_q, wd_i.data};
                    pending_q              <= 1'b1;
                    if (wd_i.sel == CMP_B_RST) rb_q <= 1'b1;
                end
                default: ;
            endcase
        end
    end

    assign staged_o  = staged_q;
    assign ctrl_o    = ctrl_q;
    assign pending_o = pending_q;
    assign rb_seen_o = rb_q;

    // R10: a transfer is only ever requested while something is pending
    a_r10_xfer_needs_pending: assert property (@(posedge clk) disable iff (rst)
        xfer_i |-> pending_q);

    // R9: a high-byte write alone never raises the pending flag
    a_r9_hi_byte_no_pending: assert property (@(posedge clk) disable iff (rst)
        (wd_i.kind == WK_CMP_HI && !pending_q) |=> !pending_q);
endmodule

// File: rtl/shadow_policy.sv
module shadow_policy
    import shadow_pkg::*;
(
    input  logic clk,
    input  logic rst,
    input  logic run_i,
    input  logic eoc_i,
    input  logic lock_i,
    input  logic autolock_i,
    input  logic pending_i,
    input  logic rb_seen_i,
    output logic xfer_o
);
    logic    trig_eff_q;
    policy_e pol;

    // The trigger-on-write bit is sampled only at a cycle boundary.
    always_ff @(posedge clk) begin
        if (rst)        trig_eff_q <= 1'b0;
        else if (eoc_i) trig_eff_q <= autolock_i;
    end

    always_comb begin
        pol    = pick_policy(trig_eff_q, lock_i);
        xfer_o = 1'b0;
        if (!run_i) begin
            xfer_o = pending_i;
        end else if (eoc_i && pending_i) begin
            unique case (pol)
                POL_TRIGGER: xfer_o = rb_seen_i;
                POL_HOLD:    xfer_o = 1'b0;
                default:     xfer_o = 1'b1;
            endcase
        end
    end

    // R3: while running, loads happen only on an end-of-cycle strobe
    a_r3_running_only_at_eoc: assert property (@(posedge clk) disable iff (rst)
        (run_i && !eoc_i) |-> !xfer_o);

    // R6: hold bit without trigger mode blocks running transfers
    a_r6_locked_hold: assert property (@(posedge clk) disable iff (rst)
        (run_i && lock_i && !trig_eff_q) |-> !xfer_o);

    // R4: trigger mode waits for the output-B reset write
    a_r4_auto_needs_rb: assert property (@(posedge clk) disable iff (rst)
        (run_i && trig_eff_q && !rb_seen_i) |-> !xfer_o);

    // R5: the effective trigger mode moves only at a cycle boundary
    a_r5_autolock_moves_at_eoc: assert property (@(posedge clk) disable iff (rst)
        !eoc_i |=> $stable(trig_eff_q));
endmodule

// File: rtl/shadow_active.sv
module shadow_active
    import shadow_pkg::*;
(
    input  logic    clk,
    input  logic    rst,
    input  logic    xfer_i,
    input  regset_t staged_i,
    input  logic    fifty_i,
    output regset_t act_o,
    output logic    done_o
);
    regset_t act_q;
    logic    done_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            act_q  <= '0;
            done_q <= 1'b0;
        end else begin
            done_q <= xfer_i;
            if (xfer_i) act_q <= staged_i;
        end
    end

    always_comb begin
        act_o = act_q;
        if (fifty_i) begin
            act_o.cmp[CMP_A_SET] = act_q.cmp[CMP_B_SET];
            act_o.cmp[CMP_A_RST] = act_q.cmp[CMP_B_RST];
        end
    end

    assign done_o = done_q;

    // R2: the active layer holds still unless a transfer was granted
    a_r2_active_held: assert property (@(posedge clk) disable iff (rst)
        !xfer_i |=> $stable(act_q));
endmodule

// File: rtl/shadow_update_ctrl.sv
module shadow_update_ctrl
    import shadow_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] wr_addr,
    input  logic [DATA_W-1:0] wr_data,
    input  logic              run,
    input  logic              eoc,
    output logic [CFG_W-1:0]  act_cfg,
    output logic              act_mode,
    output logic [CMP_W-1:0]  act_a_set,
    output logic [CMP_W-1:0]  act_a_rst,
    output logic [CMP_W-1:0]  act_b_set,
    output logic [CMP_W-1:0]  act_b_rst,
    output logic              upd_done
);
    wdec_t   wd;
    regset_t staged;
    regset_t act;
    ctrl_t   ctrl;
    logic    pending;
    logic    rb_seen;
    logic    xfer;

    assign wd = decode_write(wr_en, wr_addr, wr_data);

    shadow_stage u_stage (
        .clk       (clk),
        .rst       (rst),
        .wd_i      (wd),
        .xfer_i    (xfer),
        .staged_o  (staged),
        .ctrl_o    (ctrl),
        .pending_o (pending),
        .rb_seen_o (rb_seen)
    );

    shadow_policy u_policy (
        .clk        (clk),
        .rst        (rst),
        .run_i      (run),
        .eoc_i      (eoc),
        .lock_i     (ctrl.lock),
        .autolock_i (ctrl.autolock),
        .pending_i  (pending),
        .rb_seen_i  (rb_seen),
        .xfer_o     (xfer)
    );

    shadow_active u_active (
        .clk      (clk),
        .rst      (rst),
        .xfer_i   (xfer),
        .staged_i (staged),
        .fifty_i  (ctrl.fifty),
        .act_o    (act),
        .done_o   (upd_done)
    );

    assign act_cfg   = act.cfg;
    assign act_mode  = act.mode;
    assign act_a_set = act.cmp[CMP_A_SET];
    assign act_a_rst = act.cmp[CMP_A_RST];
    assign act_b_set = act.cmp[CMP_B_SET];
    assign act_b_rst = act.cmp[CMP_B_RST];

    // R11: a transfer with no write beside it leaves nothing pending
    a_r11_clear_after_xfer: assert property (@(posedge clk) disable iff (rst)
        (xfer && wd.kind == WK_NONE) |=> !pending);
endmodule

// File: tb/test_shadow_update_ctrl.sv
`timescale 1ns/1ps
module test_shadow_update_ctrl;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        wr_en = 1'b0;
    logic [3:0]  wr_addr = '0;
    logic [7:0]  wr_data = '0;
    logic        run = 1'b0;
    logic        eoc = 1'b0;
    logic [7:0]  act_cfg;
    logic        act_mode;
    logic [11:0] act_a_set, act_a_rst, act_b_set, act_b_rst;
    logic        upd_done;

    int checks = 0;
    int errors = 0;
    bit started = 0;
    bit finished = 0;
    string cur_req = "R1";

    always #2.5 clk = ~clk;

    shadow_update_ctrl i_shadow_update_ctrl (
        .clk(clk), .rst(rst), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
        .run(run), .eoc(eoc), .act_cfg(act_cfg), .act_mode(act_mode),
        .act_a_set(act_a_set), .act_a_rst(act_a_rst), .act_b_set(act_b_set),
        .act_b_rst(act_b_rst), .upd_done(upd_done)
    );

    // Reference model: index 0 cfg, 1 mode, 2 A set, 3 A reset, 4 B set, 5 B reset
    int m_st[6];
    int m_ac[6];
    int m_hold, m_pend, m_rbw, m_lk, m_al, m_ale, m_fifty, m_done;

    always @(posedge clk) begin
        if (rst) begin
            foreach (m_st[i]) begin m_st[i] = 0; m_ac[i] = 0; end
            m_hold = 0; m_pend = 0; m_rbw = 0; m_lk = 0; m_al = 0;
            m_ale = 0; m_fifty = 0; m_done = 0;
        end else begin
            bit go;
            if (!run)                 go = (m_pend != 0);
            else if (!eoc || !m_pend) go = 0;
            else if (m_ale != 0)      go = (m_rbw != 0);
            else                      go = (m_lk == 0);
            if (go) begin
                foreach (m_st[i]) m_ac[i] = m_st[i];
                m_pend = 0; m_rbw = 0;
            end
            m_done = go;
            if (eoc) m_ale = m_al;
            if (wr_en) begin
                int a, d;
                a = wr_addr; d = wr_data;
                if (a == 0) begin
                    m_lk = d & 1; m_al = (d >> 1) & 1; m_fifty = (d >> 2) & 1;
                end else if (a == 1) begin
                    m_st[0] = d; m_pend = 1;
                end else if (a == 2) begin
                    m_st[1] = d & 1; m_pend = 1;
                end else if (a >= 4 && a <= 11) begin
                    int k;
                    k = (a - 4) / 2;
                    if ((a % 2) == 0) m_hold = d & 15;
                    else begin
                        m_st[2 + k] = m_hold * 256 + d;
                        m_pend = 1;
                        if (k == 3) m_rbw = 1;
                    end
                end
            end
        end
    end

    task automatic chk(input string req, input string what, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
        end
    endtask

    // Every-cycle comparison against the model
    always @(negedge clk) begin
        if (started && !finished) begin
            chk(cur_req, "model cfg", int'(act_cfg), m_ac[0]);
            chk(cur_req, "model mode", int'(act_mode), m_ac[1]);
            chk(cur_req, "model a_set", int'(act_a_set), m_fifty ? m_ac[4] : m_ac[2]);
            chk(cur_req, "model a_rst", int'(act_a_rst), m_fifty ? m_ac[5] : m_ac[3]);
            chk(cur_req, "model b_set", int'(act_b_set), m_ac[4]);
            chk(cur_req, "model b_rst", int'(act_b_rst), m_ac[5]);
            chk(cur_req, "model done", int'(upd_done), m_done);
        end
    end

    task automatic cyc(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic wr(input int a, input int d);
        wr_en = 1'b1; wr_addr = 4'(a); wr_data = 8'(d);
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic wr_eoc(input int a, input int d);
        eoc = 1'b1;
        wr(a, d);
        eoc = 1'b0;
    endtask

    task automatic pulse_eoc();
        eoc = 1'b1;
        @(negedge clk);
        eoc = 1'b0;
    endtask

    task automatic summary();
        $display("Result: errors=%0d of %0d checks", errors, checks);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        if (!finished) begin
            finished = 1;
            checks++; errors++;
            $display("FAIL watchdog: actual hung expected finish");
            summary();
            $finish;
        end
    end

    initial begin
        cyc(3);
        started = 1;
        rst = 1'b0;
        // R1 reset state
        cur_req = "R1";
        chk("R1", "cfg after reset", int'(act_cfg), 0);
        chk("R1", "b_rst after reset", int'(act_b_rst), 0);
        chk("R1", "done after reset", int'(upd_done), 0);

        // R2 stopped: immediate
        cur_req = "R2";
        wr(1, 8'hA5);
        chk("R2", "cfg before load", int'(act_cfg), 0);
        cyc(1);
        chk("R2", "cfg loaded", int'(act_cfg), 8'hA5);
        chk("R2", "done pulse", int'(upd_done), 1);
        cyc(1);
        chk("R2", "done one cycle", int'(upd_done), 0);

        // R9 byte pairing
        cur_req = "R9";
        wr(10, 8'h0B);
        cyc(2);
        chk("R9", "high byte alone", int'(act_b_rst), 0);
        chk("R9", "no done on high byte", int'(upd_done), 0);
        wr(11, 8'hCD);
        cyc(1);
        chk("R9", "b_rst committed", int'(act_b_rst), 12'hBCD);
        wr(4, 8'h01); wr(5, 8'h23);
        wr(6, 8'h02); wr(7, 8'h34);
        wr(8, 8'h03); wr(9, 8'h45);
        wr(2, 8'h01);
        cyc(1);
        chk("R9", "a_set", int'(act_a_set), 12'h123);
        chk("R9", "a_rst", int'(act_a_rst), 12'h234);
        chk("R9", "b_set", int'(act_b_set), 12'h345);

        // R3 running, free
        cur_req = "R3";
        run = 1'b1;
        wr(1, 8'h3C);
        cyc(3);
        chk("R3", "held before eoc", int'(act_cfg), 8'hA5);
        chk("R3", "no done before eoc", int'(upd_done), 0);
        pulse_eoc();
        chk("R3", "loaded at eoc", int'(act_cfg), 8'h3C);
        chk("R3", "mode kept", int'(act_mode), 1);
        chk("R3", "done at eoc", int'(upd_done), 1);
        cyc(1);
        chk("R3", "done single", int'(upd_done), 0);

        // R10 nothing pending
        cur_req = "R10";
        pulse_eoc();
        chk("R10", "no done idle eoc", int'(upd_done), 0);

        // R11 write coinciding with eoc
        cur_req = "R11";
        wr(1, 8'h11);
        wr_eoc(1, 8'h22);
        chk("R11", "old set moved", int'(act_cfg), 8'h11);
        chk("R11", "done", int'(upd_done), 1);
        cyc(1);
        pulse_eoc();
        chk("R11", "late write next eoc", int'(act_cfg), 8'h22);

        // R6 hold bit
        cur_req = "R6";
        wr(0, 1);
        wr(1, 8'h44);
        pulse_eoc();
        chk("R6", "held by lock", int'(act_cfg), 8'h22);
        chk("R6", "no done locked", int'(upd_done), 0);
        wr(0, 0);
        cyc(1);
        chk("R6", "clear alone no move", int'(act_cfg), 8'h22);
        pulse_eoc();
        chk("R6", "moves after clear", int'(act_cfg), 8'h44);

        // R5 and R4 trigger mode
        cur_req = "R5";
        wr(0, 2);
        wr(1, 8'h55);
        pulse_eoc();
        chk("R5", "first eoc old rule", int'(act_cfg), 8'h55);
        cur_req = "R4";
        wr(1, 8'h66);
        pulse_eoc();
        chk("R4", "other write no move", int'(act_cfg), 8'h55);
        chk("R4", "no done", int'(upd_done), 0);
        wr(10, 8'h0E); wr(11, 8'h77);
        cyc(1);
        chk("R4", "no move before eoc", int'(act_cfg), 8'h55);
        pulse_eoc();
        chk("R4", "moved after rb write", int'(act_cfg), 8'h66);
        chk("R4", "rb value", int'(act_b_rst), 12'hE77);

        // R7 priority
        cur_req = "R7";
        wr(0, 3);
        wr(1, 8'h88);
        wr(10, 8'h00); wr(11, 8'h99);
        pulse_eoc();
        chk("R7", "trigger beats hold", int'(act_cfg), 8'h88);

        // R5 clearing trigger mode
        cur_req = "R5";
        wr(0, 0);
        wr(1, 8'h9A);
        pulse_eoc();
        chk("R5", "still trigger rule", int'(act_cfg), 8'h88);
        pulse_eoc();
        chk("R5", "free rule after eoc", int'(act_cfg), 8'h9A);

        // R8 mirror
        cur_req = "R8";
        wr(0, 4);
        chk("R8", "a_set mirrors", int'(act_a_set), 12'h345);
        chk("R8", "a_rst mirrors", int'(act_a_rst), 12'h099);
        wr(0, 0);
        chk("R8", "a_set own", int'(act_a_set), 12'h123);
        chk("R8", "a_rst own", int'(act_a_rst), 12'h234);

        // R1 reset while running
        cur_req = "R1";
        rst = 1'b1;
        cyc(1);
        chk("R1", "cfg mid reset", int'(act_cfg), 0);
        chk("R1", "a_set mid reset", int'(act_a_set), 0);
        rst = 1'b0;
        cyc(2);

        finished = 1;
        summary();
        $finish;
    end
endmodule